// File: doc/BRIEF.md
# Host Frame Staging Buffer

This block lets a host processor move whole frames to and from word-wide buffer memory without ever waiting on that memory directly. All data passes through one small staging FIFO. The host sees a single data window and a few register locations. The block runs a request/acknowledge word port toward the memory side.

For receive, a start pulse names the frame's memory address. The block fetches the header word first. It takes the frame length from the header's low byte and prefetches until the FIFO holds eight words or the frame ends. A packet-ready flag tells the host that a half-buffer of four words is waiting. The host reads the window four times and then writes the receive go location. The block refills the free half, and the host polls the same location until it reads set again.

For transmit, a start pulse names the destination address. The host writes header and payload words into the window, then writes the transmit go location. The block drains the FIFO to consecutive memory words. It never issues a memory read past the frame length, and it never writes to a full FIFO.

Top module: `hfs_stage`

## Requirements
- R1: After reset, no memory request is made, the packet-ready flag is 0, the status location reads 0, and both go locations read bit0 = 1.
- R2: A receive start pulse while idle flushes the FIFO and reads the header from the given address. The frame length L is header bits [7:0], counts the header, and a value of 0 is taken as 1. The block then reads min(7, L-1) more words from consecutive addresses.
- R3: The packet-ready output is 1 exactly when the block is in receive mode and at least four words sit in the FIFO.
- R4: A window read (host address 0) in receive mode returns the oldest word and removes it, header first. On an empty FIFO it returns 0 and sets status bit1. That bit stays set until the host writes status (address 3) with bit1 = 1.
- R5: A write to address 1 while idle in receive mode fetches min(4, words left in frame, free slots). Address 1 reads bit0 = 0 while a fetch runs and 1 otherwise. The total number of memory reads per frame equals L.
- R6: A transmit start pulse while idle flushes the FIFO and sets the write address. Window writes append words, and a write to a full FIFO is dropped. A write to address 2 drains every queued word, in order, to consecutive addresses. Address 2 reads bit0 = 0 while draining.
- R7: Once a memory request is raised, it stays high with stable address and direction until acknowledged.
- R8: Reading status (bit0 mirrors packet-ready) or polling the go locations changes neither FIFO contents nor the flag.
- R9: In receive mode, window writes are ignored. In transmit mode, window reads return 0, remove nothing and leave status bit1 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_start_i | input | 1 | Begin receive of a frame |
| rx_addr_i | input | 16 | Memory word address of receive frame header |
| tx_start_i | input | 1 | Begin transmit of a frame |
| tx_addr_i | input | 16 | Memory word address for transmit frame |
| host_req_i | input | 1 | Host access strobe, one cycle per access |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 2 | 0 window, 1 receive go, 2 transmit go, 3 status |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data, valid during the strobe |
| pkt_ready_o | output | 1 | Four or more receive words waiting |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, completes one word |

## Verification
The bench runs random frame lengths, including a zero length field, single-word frames and lengths that are not a multiple of four. A design that prefetched past the end of the frame would show more memory reads than L. A design that miscounted the half-buffer refill would return words out of order, or leave the host stuck polling a go location that never sets. Reads past the frame end must give zero and a sticky underflow that survives polling and clears only on the explicit write; a design that cleared it on read would fail. Nine transmit writes without a drain check that the ninth is dropped and the word after the eighth is left untouched in memory.

// File: rtl/hfs_pkg.sv
package hfs_pkg;
  typedef enum logic [1:0] {
    HREG_WINDOW = 2'd0,
    HREG_RXGO   = 2'd1,
    HREG_TXGO   = 2'd2,
    HREG_STAT   = 2'd3
  } hreg_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2
  } eng_state_e;
endpackage

// File: rtl/hfs_fifo.sv
module hfs_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] slot_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic          do_push, do_pop;

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign head_o  = slot_q[rd_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           slot_q[i] <= '0;
      else if (do_push && wr_q == PW'(i))    slot_q[i] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; count_o <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; count_o <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      count_o <= count_o + CW'(do_push) - CW'(do_pop);
    end
  end

  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && count_o == CW'(DEPTH));
endmodule

// File: rtl/hfs_engine.sv
module hfs_engine #(
  parameter int AW    = 16,
  parameter int LW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_start_i,
  input  logic [AW-1:0] rx_addr_i,
  input  logic          tx_start_i,
  input  logic [AW-1:0] tx_addr_i,
  input  logic          rx_go_i,
  input  logic          tx_go_i,
  input  logic [CW-1:0] fifo_count_i,
  input  logic [LW-1:0] hdr_word_i,
  input  logic          mem_ack_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          flush_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          rx_mode_o,
  output logic          rx_busy_o,
  output logic          tx_busy_o
);
  import hfs_pkg::*;
  localparam logic [LW-1:0] HALF_L  = LW'(DEPTH / 2);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  eng_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q, burst_q;
  logic          hdr_pend_q, rx_mode_q;
  logic          idle, xfer;
  logic [LW-1:0] hdr_len, first_burst, free_w, refill;

  function automatic logic [LW-1:0] min2(input logic [LW-1:0] a, input logic [LW-1:0] b);
    return (a < b) ? a : b;
  endfunction

  always_comb begin
    idle        = (state_q == ST_IDLE);
    xfer        = mem_req_o && mem_ack_i;
    hdr_len     = (hdr_word_i == '0) ? LW'(1) : hdr_word_i;
    first_burst = min2(hdr_len - LW'(1), DEPTH_L - LW'(1));
    free_w      = DEPTH_L - LW'(fifo_count_i);
    refill      = min2(min2(HALF_L, rem_q), free_w);
  end

  assign mem_req_o  = !idle;
  assign mem_we_o   = (state_q == ST_DRAIN);
  assign mem_addr_o = addr_q;
  assign flush_o    = idle && (rx_start_i || tx_start_i);
  assign push_o     = (state_q == ST_FETCH) && xfer;
  assign pop_o      = (state_q == ST_DRAIN) && xfer;
  assign rx_mode_o  = rx_mode_q;
  assign rx_busy_o  = (state_q == ST_FETCH);
  assign tx_busy_o  = (state_q == ST_DRAIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; addr_q <= '0; rem_q <= '0; burst_q <= '0;
      hdr_pend_q <= 1'b0; rx_mode_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (rx_start_i) begin
            rx_mode_q <= 1'b1; addr_q <= rx_addr_i; hdr_pend_q <= 1'b1;
            rem_q <= '0; burst_q <= LW'(1); state_q <= ST_FETCH;
          end else if (tx_start_i) begin
            rx_mode_q <= 1'b0; addr_q <= tx_addr_i;
          end else if (rx_go_i && rx_mode_q && refill != '0) begin
            burst_q <= refill; state_q <= ST_FETCH;
          end else if (tx_go_i && !rx_mode_q && fifo_count_i != '0) begin
            state_q <= ST_DRAIN;
          end
        end
        ST_FETCH: if (xfer) begin
          addr_q <= addr_q + 1'b1;
          if (hdr_pend_q) begin
            hdr_pend_q <= 1'b0;
            rem_q      <= hdr_len - LW'(1);
            burst_q    <= first_burst;
            if (first_burst == '0) state_q <= ST_IDLE;
          end else begin
            rem_q   <= rem_q - LW'(1);
            burst_q <= burst_q - LW'(1);
            if (burst_q == LW'(1)) state_q <= ST_IDLE;
          end
        end
        ST_DRAIN: if (xfer) begin
          addr_q <= addr_q + 1'b1;
          if (fifo_count_i == CW'(1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_req_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  p_no_overfetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && !hdr_pend_q |-> rem_q != '0);
  p_write_only_tx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !rx_mode_q);
endmodule

// File: rtl/hfs_stage.sv
module hfs_stage #(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int LW    = 8,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_start_i,
  input  logic [AW-1:0] rx_addr_i,
  input  logic          tx_start_i,
  input  logic [AW-1:0] tx_addr_i,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [1:0]    host_addr_i,
  input  logic [DW-1:0] host_wdata_i,
  output logic [DW-1:0] host_rdata_o,
  output logic          pkt_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i
);
  import hfs_pkg::*;

  logic          flush, eng_push, eng_pop, rx_mode, rx_busy, tx_busy;
  logic          full, empty, uflow_q;
  logic [CW-1:0] count;
  logic [DW-1:0] head;
  logic          win_rd, win_wr, host_pop, host_push, rx_go, tx_go, uflow_set, uflow_clr;
  hreg_e         reg_sel;

  always_comb begin
    reg_sel   = hreg_e'(host_addr_i);
    win_rd    = host_req_i && !host_we_i && reg_sel == HREG_WINDOW;
    win_wr    = host_req_i &&  host_we_i && reg_sel == HREG_WINDOW;
    host_pop  = win_rd && rx_mode && !empty;
    host_push = win_wr && !rx_mode;
    uflow_set = win_rd && rx_mode && empty;
    uflow_clr = host_req_i && host_we_i && reg_sel == HREG_STAT && host_wdata_i[1];
    rx_go     = host_req_i && host_we_i && reg_sel == HREG_RXGO;
    tx_go     = host_req_i && host_we_i && reg_sel == HREG_TXGO;
    case (reg_sel)
      HREG_WINDOW: host_rdata_o = (rx_mode && !empty) ? head : '0;
      HREG_RXGO:   host_rdata_o = DW'(!rx_busy);
      HREG_TXGO:   host_rdata_o = DW'(!tx_busy);
      default:     host_rdata_o = DW'({uflow_q, pkt_ready_o});
    endcase
  end

  assign pkt_ready_o = rx_mode && (count >= CW'(DEPTH / 2));
  assign mem_wdata_o = head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        uflow_q <= 1'b0;
    else if (uflow_set) uflow_q <= 1'b1;
    else if (uflow_clr) uflow_q <= 1'b0;
  end

  hfs_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(eng_push || host_push),
    .push_data_i(rx_mode ? mem_rdata_i : host_wdata_i),
    .pop_i(eng_pop || host_pop),
    .head_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  hfs_engine #(.AW(AW), .LW(LW), .DEPTH(DEPTH)) u_engine (
    .clk_i, .rst_ni, .rx_start_i, .rx_addr_i, .tx_start_i, .tx_addr_i,
    .rx_go_i(rx_go), .tx_go_i(tx_go), .fifo_count_i(count),
    .hdr_word_i(mem_rdata_i[LW-1:0]), .mem_ack_i,
    .mem_req_o, .mem_we_o, .mem_addr_o,
    .flush_o(flush), .push_o(eng_push), .pop_o(eng_pop),
    .rx_mode_o(rx_mode), .rx_busy_o(rx_busy), .tx_busy_o(tx_busy)
  );

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && !mem_we_o |-> !full);
  p_flag_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_ready_o) |-> $past(mem_req_o && mem_ack_i));
  p_uflow_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uflow_q && !uflow_clr |=> uflow_q);
  p_poll_no_pop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_we_i && reg_sel != HREG_WINDOW && !mem_ack_i && !flush |=> $stable(count));
endmodule

// File: tb/hfs_stage_tb_top.sv
`timescale 1ns/1ps
module hfs_stage_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rx_start = 0, tx_start = 0, host_req = 0, host_we = 0;
  logic [15:0] rx_addr = 0, tx_addr = 0, host_wdata = 0, host_rdata;
  logic [1:0]  host_addr = 0;
  logic        pkt_ready, mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [15:0] mem [256];
  int          rd_acks, n_chk, n_fail, cyc;

  always #4 clk = ~clk;

  hfs_stage dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_start_i(rx_start), .rx_addr_i(rx_addr),
    .tx_start_i(tx_start), .tx_addr_i(tx_addr), .host_req_i(host_req),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .pkt_ready_o(pkt_ready), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack && ($urandom % 3 != 0);
      if (mem_req && mem_ack) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        else rd_acks <= rd_acks + 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hrd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); host_req = 1; host_we = 0; host_addr = a;
    #1 d = host_rdata;
    @(posedge clk); #1 host_req = 0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1 host_req = 0; host_we = 0;
  endtask

  task automatic poll(input logic [1:0] a, input string tag);
    logic [15:0] d;
    for (int i = 0; i < 300; i++) begin
      hrd(a, d);
      if (d[0]) return;
    end
    check(0, tag, 0, 1);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic rx_frame(input int base, input int lfield);
    int L, fetched, cnt, idx, f, acks0;
    logic [15:0] d;
    L = (lfield == 0) ? 1 : lfield;
    for (int i = 0; i < L + 8; i++) mem[(base + i) % 256] = 16'($urandom);
    mem[base % 256] = {8'($urandom), 8'(lfield)};
    acks0 = rd_acks;
    @(negedge clk); rx_start = 1; rx_addr = 16'(base);
    @(posedge clk); #1 rx_start = 0;
    poll(2'd1, "R2 initial prefetch done");
    fetched = imin(8, L); cnt = fetched; idx = 0;
    while (idx < L) begin
      check(pkt_ready == (cnt >= 4), "R3 pkt flag", pkt_ready, cnt >= 4);
      hrd(2'd3, d);
      check(d[0] == (cnt >= 4), "R8 status mirrors flag", d[0], cnt >= 4);
      for (int k = 0; k < imin(4, cnt); k++) begin
        hrd(2'd0, d);
        check(d == mem[(base + idx) % 256], "R4 window order", d, mem[(base + idx) % 256]);
        idx++;
      end
      cnt -= imin(4, cnt);
      if (fetched < L) begin
        f = imin(imin(4, L - fetched), 8 - cnt);
        hwr(2'd1, 16'h1);
        hrd(2'd1, d);
        check(d[0] == 1'b0, "R5 go busy", d[0], 0);
        poll(2'd1, "R5 go completes");
        cnt += f; fetched += f;
      end
    end
    check(rd_acks - acks0 == L, "R5 R2 read count", rd_acks - acks0, L);
    hwr(2'd0, 16'hBEEF);
    hrd(2'd0, d);
    check(d == 0, "R4 R9 empty read zero", d, 0);
    hrd(2'd3, d);
    check(d[1] == 1'b1, "R4 underflow set", d[1], 1);
    hrd(2'd1, d);
    hrd(2'd3, d);
    check(d[1] == 1'b1, "R4 underflow sticky", d[1], 1);
    hwr(2'd3, 16'h2);
    hrd(2'd3, d);
    check(d[1] == 1'b0, "R4 underflow cleared", d[1], 0);
  endtask

  task automatic tx_frame(input int base, input int L);
    logic [15:0] w [64];
    logic [15:0] d;
    int sent;
    for (int i = 0; i < L; i++) w[i] = (i == 0) ? {8'h5A, 8'(L)} : 16'($urandom);
    @(negedge clk); tx_start = 1; tx_addr = 16'(base);
    @(posedge clk); #1 tx_start = 0;
    hrd(2'd0, d);
    check(d == 0, "R9 tx window read zero", d, 0);
    hrd(2'd3, d);
    check(d[1] == 1'b0, "R9 tx read no underflow", d[1], 0);
    sent = 0;
    while (sent < L) begin
      for (int k = 0; k < imin(4, L - sent); k++) hwr(2'd0, w[sent + k]);
      sent += imin(4, L - sent);
      hwr(2'd2, 16'h1);
      hrd(2'd2, d);
      check(d[0] == 1'b0, "R6 drain busy", d[0], 0);
      poll(2'd2, "R6 drain completes");
    end
    for (int i = 0; i < L; i++)
      check(mem[(base + i) % 256] == w[i], "R6 memory contents", mem[(base + i) % 256], w[i]);
  endtask

  initial begin
    logic [15:0] d, guard;
    void'($urandom(32'h2468));
    rd_acks = 0; n_chk = 0; n_fail = 0;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(mem_req == 0, "R1 no request", mem_req, 0);
    check(pkt_ready == 0, "R1 flag low", pkt_ready, 0);
    hrd(2'd3, d); check(d == 0, "R1 status", d, 0);
    hrd(2'd1, d); check(d[0] == 1, "R1 rx go idle", d[0], 1);
    hrd(2'd2, d); check(d[0] == 1, "R1 tx go idle", d[0], 1);
    rx_frame(10, 0);
    rx_frame(20, 1);
    rx_frame(30, 3);
    rx_frame(40, 8);
    rx_frame(60, 13);
    tx_frame(120, 1);
    tx_frame(130, 6);
    for (int t = 0; t < 6; t++) begin
      rx_frame(int'($urandom % 200), int'($urandom % 31));
      tx_frame(int'($urandom % 200), 1 + int'($urandom % 20));
    end
    // nine writes without a drain: ninth dropped
    guard = mem[208];
    @(negedge clk); tx_start = 1; tx_addr = 16'd200;
    @(posedge clk); #1 tx_start = 0;
    for (int k = 0; k < 9; k++) hwr(2'd0, 16'h1000 + 16'(k));
    hwr(2'd2, 16'h1);
    poll(2'd2, "R6 full drain completes");
    for (int k = 0; k < 8; k++)
      check(mem[200 + k] == 16'h1000 + 16'(k), "R6 full fifo contents", mem[200 + k], 16'h1000 + k);
    check(mem[208] == guard, "R6 ninth write dropped", mem[208], guard);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end
endmodule